// File: doc/BRIEF.md
# Selectable Adder/Magnitude Comparator Unit

This unit is purely combinational. It takes two small unsigned operands and one mode bit, and drives a single result bus. With the mode bit high, the bus carries the complete sum of the operands, and the carry sits in the top bit. With the mode bit low, the bus carries a two-bit relation code that says how the operands compare, and the top bit is held at zero.

A comparator inside the unit produces the relation code. It has an enable input, and when that enable is low it drives the code to zero. Inside this unit the enable is tied active, so compare mode always yields a non-zero code. The unit has no clock and no state. It has no data stream, so it has no valid/ready handshake: the result follows the inputs after gate delay only.

Top module: `addcmp_unit`

## Requirements
- R1: With `add_mode` = 1, `result` equals the unsigned sum `op_a + op_b`, three bits wide, for every operand pair.
- R2: With `add_mode` = 1 and a sum of 4 or more, the carry-out appears in `result[2]`, and `result[1:0]` holds the sum modulo 4.
- R3: With `add_mode` = 0 and `op_a` < `op_b`, `result[1:0]` = 2'b01.
- R4: With `add_mode` = 0 and `op_a` > `op_b`, `result[1:0]` = 2'b10.
- R5: With `add_mode` = 0 and `op_a` = `op_b`, `result[1:0]` = 2'b11.
- R6: With `add_mode` = 0, `result[2]` is 0 for every operand pair.
- R7: The comparator enable is held active, so in compare mode `result` is never 3'b000.
- R8: `result` depends only on the present inputs. It settles to the correct value for any input change, whatever the previous inputs were, and no clock is involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 2 | First unsigned operand |
| op_b | input | 2 | Second unsigned operand |
| add_mode | input | 1 | 1 selects the sum, 0 selects the relation code |
| result | output | 3 | Sum with carry in bit 2, or zero-extended relation code |

## Verification
A bad carry link in the adder chain shows at once as a wrong bit in `result` for sums that carry, such as 1+1 or 3+1. A mis-ordered comparison, or an enable stuck low, shows as a swapped or zero relation code on the first unequal or equal pair in compare mode. The bench applies all 32 input combinations and then random sequences of them, so any error of either kind is seen on the first vector that reaches it. The random sequences also catch any result that depends on the order of the vectors.

// File: rtl/addcmp_pkg.sv
package addcmp_pkg;
  localparam int unsigned REL_W = 2;
  typedef logic [REL_W-1:0] rel_code_t;
  localparam rel_code_t REL_NONE = 2'b00;
  localparam rel_code_t REL_LT   = 2'b01;
  localparam rel_code_t REL_GT   = 2'b10;
  localparam rel_code_t REL_EQ   = 2'b11;
  typedef enum logic {MODE_CMP = 1'b0, MODE_ADD = 1'b1} unit_mode_e;
endpackage

// File: rtl/addcmp_ripple_add.sv
module addcmp_ripple_add #(
  parameter int unsigned W = 2
) (
  input  logic [W-1:0] in_x,
  input  logic [W-1:0] in_y,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] chain;
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_o[i]   = in_x[i] ^ in_y[i] ^ chain[i];
    assign chain[i+1] = (in_x[i] & in_y[i]) | (chain[i] & (in_x[i] ^ in_y[i]));
  end
  assign cout_o = chain[W];
endmodule

// File: rtl/addcmp_magcmp.sv
module addcmp_magcmp
  import addcmp_pkg::*;
#(
  parameter int unsigned W = 2
) (
  input  logic [W-1:0] in_x,
  input  logic [W-1:0] in_y,
  input  logic         cmp_en,
  output rel_code_t    code_o
);
  // Scan from the MSB down; the first differing bit decides.
  logic [W:0] undecided;
  logic [W-1:0] x_wins, y_wins;
  assign undecided[W] = 1'b1;
  for (genvar i = W - 1; i >= 0; i--) begin : g_scan
    assign x_wins[i]    = undecided[i+1] & in_x[i] & ~in_y[i];
    assign y_wins[i]    = undecided[i+1] & ~in_x[i] & in_y[i];
    assign undecided[i] = undecided[i+1] & ~(in_x[i] ^ in_y[i]);
  end
  always_comb begin
    if (!cmp_en)            code_o = REL_NONE;
    else if (undecided[0])  code_o = REL_EQ;
    else if (|x_wins)       code_o = REL_GT;
    else                    code_o = REL_LT;
  end
endmodule

// File: rtl/addcmp_unit.sv
module addcmp_unit
  import addcmp_pkg::*;
#(
  parameter int unsigned W = 2,
  localparam int unsigned RW = W + 1
) (
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic          add_mode,
  output logic [RW-1:0] result
);
  logic [W-1:0] sum_lo;
  logic         sum_c;
  rel_code_t    rel;

  addcmp_ripple_add #(.W(W)) u_add (
    .in_x(op_a), .in_y(op_b), .sum_o(sum_lo), .cout_o(sum_c)
  );

  addcmp_magcmp #(.W(W)) u_cmp (
    .in_x(op_a), .in_y(op_b), .cmp_en(1'b1), .code_o(rel)
  );

  always_comb begin
    if (unit_mode_e'(add_mode) == MODE_ADD) result = {sum_c, sum_lo};
    else                                    result = RW'(rel);
  end
endmodule

// File: rtl/addcmp_unit_chk.sv
module addcmp_unit_chk #(
  parameter int unsigned W = 2,
  localparam int unsigned RW = W + 1
) (
  input logic [W-1:0]  op_a,
  input logic [W-1:0]  op_b,
  input logic          add_mode,
  input logic [RW-1:0] result
);
  always_comb begin
    if (!$isunknown({op_a, op_b, add_mode})) begin
      if (add_mode)
        AST_SUM_MATCH: assert (result == RW'(op_a) + RW'(op_b)); // R1
      if (!add_mode)
        AST_CMP_TOP_ZERO: assert (result[RW-1] == 1'b0); // R6
      if (!add_mode)
        AST_CMP_NONZERO: assert (result != '0); // R7
      if (!add_mode)
        AST_EQ_CODE: assert ((result[1:0] == 2'b11) == (op_a == op_b)); // R5
      if (!add_mode && op_a < op_b)
        AST_LT_CODE: assert (result[1:0] == 2'b01); // R3
      if (!add_mode && op_a > op_b)
        AST_GT_CODE: assert (result[1:0] == 2'b10); // R4
    end
  end
endmodule

bind addcmp_unit addcmp_unit_chk #(.W(W)) u_chk (
  .op_a(op_a), .op_b(op_b), .add_mode(add_mode), .result(result)
);

// File: tb/tb_addcmp_unit.sv
module tb_addcmp_unit;
  localparam int unsigned W = 2;
  localparam int unsigned RW = W + 1;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic add_mode = 1'b0;
  logic [RW-1:0] result;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addcmp_unit #(.W(W)) dut (.op_a(op_a), .op_b(op_b), .add_mode(add_mode), .result(result));

  function automatic logic [RW-1:0] model(input int a, input int b, input bit m);
    if (m) return RW'(a + b);
    if (a < b) return 3'b001;
    if (a > b) return 3'b010;
    return 3'b011;
  endfunction

  function automatic string tag_of(input int a, input int b, input bit m);
    if (m) return (a + b >= 4) ? "R2" : "R1";
    if (a < b) return "R3";
    if (a > b) return "R4";
    return "R5";
  endfunction

  task automatic apply(input int a, input int b, input bit m, input string extra);
    logic [RW-1:0] exp;
    op_a = W'(a); op_b = W'(b); add_mode = m;
    #(CLK_PERIOD/2);
    exp = model(a, b, m);
    n_tests++;
    if (result !== exp) begin
      n_fail++;
      $display("FAIL %s%s a=%0d b=%0d mode=%0d actual=%b expected=%b",
               tag_of(a, b, m), extra, a, b, m, result, exp);
    end
    if (!m) begin
      n_tests++;
      if (result[2] !== 1'b0 || result === 3'b000) begin
        n_fail++;
        $display("FAIL R6/R7 a=%0d b=%0d actual=%b expected=0xx nonzero", a, b, result);
      end
    end
    #(CLK_PERIOD/2);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned r;
    #(CLK_PERIOD);
    rst_n = 1'b1;
    // reset state: all-zero inputs in compare mode give the equal code (R5)
    apply(0, 0, 1'b0, "");
    // directed corners: largest sum with carry (R2), zero sum (R1)
    apply(3, 3, 1'b1, "");
    apply(0, 0, 1'b1, "");
    apply(2, 2, 1'b1, "");
    apply(0, 3, 1'b0, "");
    apply(3, 0, 1'b0, "");
    // exhaustive sweep of all 32 combinations
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
          apply(a, b, m[0], "");
    // R8: random order, result must track present inputs only
    r = $urandom(32'd2024);
    for (int k = 0; k < 300; k++) begin
      r = $urandom;
      apply(int'(r[1:0]), int'(r[3:2]), r[4], " R8");
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule